// File: doc/BRIEF.md
# Leg Stream Output Router and Formatter

This block sits at the output of a two-leg sample pipeline. It takes a signed upper-leg sample and a signed lower-leg sample, both qualified by one valid strobe. It places them on two 16-bit output ports, A and B, in one of four arrangements:

- The legs can be summed onto A.
- They can be passed straight through, with upper on A and lower on B.
- For the two interpolating modes, they can be interleaved onto A at twice the leg rate, or handed out side by side so that logic downstream can do the interleaving.

Every word that leaves the block goes through the same conditioning path. The path first rounds to a chosen precision between 8 and 16 bits. It then clamps the result to the 16-bit range. Last, it writes the word as either two's complement or offset binary.

Each output port registers its data and has its own valid flag. The data registers keep their value while no new word is produced. The configuration inputs are sampled on the same clock edge as the data they apply to.

Top module: `leg_route_fmt`

## Requirements
- R1: While rstN is low and after its release, until the first valid input: aValid, bValid, aOut and bOut are all 0.
- R2: With modeSel=00, a valid leg pair produces aValid one cycle later, with aOut = format(upperLeg + lowerLeg); bValid stays low.
- R3: With modeSel=10, a valid leg pair produces both valids one cycle later, with aOut = format(upperLeg) and bOut = format(lowerLeg).
- R4: With modeSel=01 or 11 and intMux=1, a valid pair gives aOut = format(upperLeg) with aValid one cycle later, then aOut = format(lowerLeg) with aValid on the following cycle; bValid stays low.
- R5: With modeSel=01 or 11 and intMux=0, the pair is sent out as in R3: upper on A, lower on B, both valid one cycle later.
- R6: rndSel values 0..7 keep 16, 15, 14, 13, 12, 10, 9 and 8 bits; that is, d = 0,1,2,3,4,6,7,8 low bits are dropped. The value is rounded by adding 2^(d-1) when d>0, then the d low bits are cleared.
- R7: After rounding, the value is clamped to the range [-32768, 32768 - 2^d]. The upper limit is the largest 16-bit value whose d low bits are zero.
- R8: With fmtOffset=0 the word is two's complement. With fmtOffset=1 the word is the same value with bit 15 inverted (offset binary).
- R9: In a cycle that produces no word for a port, that port's valid is low and its data holds the last word it carried.
- R10: A legValid that arrives in the cycle where the held lower sample of an interleave is being emitted is ignored. That pair produces no output at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| legValid | input | 1 | Upper and lower leg samples are valid |
| upperLeg | input | LEG_W (18) | Upper (real) leg sample, signed |
| lowerLeg | input | LEG_W (18) | Lower (imaginary) leg sample, signed |
| modeSel | input | 2 | Routing mode: 00 sum, 10 pass-through, 01/11 interpolating |
| intMux | input | 1 | In interpolating modes: 1 interleaves onto A, 0 sends the legs out on A and B |
| fmtOffset | input | 1 | 0 two's complement, 1 offset binary |
| rndSel | input | 3 | Precision select, see R6 |
| aOut | output | OUT_W (16) | Port A word |
| aValid | output | 1 | Port A word is new this cycle |
| bOut | output | OUT_W (16) | Port B word |
| bValid | output | 1 | Port B word is new this cycle |

## Verification
The assertions check these properties on every cycle:
- An interleave always owns the following slot of port A.
- Port B stays quiet in the summing mode.
- Cleared low bits always match the precision that was selected.
- An idle port A holds its data.
- A plain pass-through word equals its input when the input is in range.

Only the bench's sweeps can show the exact arithmetic. The bench sweeps every mode, multiplex choice, format and precision against saturating and rounding-edge data. This covers the half-LSB carry, clamping of large sums to the precision-dependent upper limit, and the offset-binary encoding. The bench scenarios also show the dropped input during the second interleave slot.

// File: rtl/leg_route_pkg.sv
package leg_route_pkg;

  typedef enum logic [1:0] {
    SRC_SUM   = 2'd0,
    SRC_UPPER = 2'd1,
    SRC_LOWER = 2'd2,
    SRC_HELD  = 2'd3
  } aSrc_e;

  typedef struct packed {
    logic  loadA;
    logic  loadB;
    logic  holdLower;
    aSrc_e aSrc;
  } routeStrobe_t;

  // number of low bits removed for each precision select code
  function automatic int unsigned dropBits(input logic [2:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 3;
      3'd4:    return 4;
      3'd5:    return 6;
      3'd6:    return 7;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/leg_route_ctrl.sv
module leg_route_ctrl
  import leg_route_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         legValid,
  input  logic [1:0]   modeSel,
  input  logic         intMux,
  output routeStrobe_t strobe
);

  logic pendLower;

  always_comb begin
    strobe = '0;
    strobe.aSrc = SRC_SUM;
    if (pendLower) begin
      // second interleave slot owns port A; a new pair is dropped
      strobe.loadA = 1'b1;
      strobe.aSrc  = SRC_HELD;
    end else if (legValid) begin
      unique case (modeSel)
        2'b00: begin
          strobe.loadA = 1'b1;
          strobe.aSrc  = SRC_SUM;
        end
        2'b10: begin
          strobe.loadA = 1'b1;
          strobe.loadB = 1'b1;
          strobe.aSrc  = SRC_UPPER;
        end
        default: begin
          strobe.loadA = 1'b1;
          strobe.aSrc  = SRC_UPPER;
          if (intMux) strobe.holdLower = 1'b1;
          else        strobe.loadB     = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendLower <= 1'b0;
    else       pendLower <= strobe.holdLower;
  end

  // R4: an interleaved pair always fills the next port A slot with the held lower sample
  a_r4_second_slot: assert property (@(posedge clk) disable iff (!rstN)
    (legValid && !pendLower && modeSel[0] && intMux)
      |=> (strobe.loadA && strobe.aSrc == SRC_HELD && !strobe.loadB));

  // R10: nothing new is accepted while the held sample goes out
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    pendLower |=> !pendLower);

endmodule

// File: rtl/leg_word_fmt.sv
module leg_word_fmt
  import leg_route_pkg::*;
#(
  parameter int IN_W  = 19,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0] dataIn,
  input  logic [2:0]             rndSel,
  input  logic                   fmtOffset,
  output logic [OUT_W-1:0]       wordOut
);

  localparam int RW = (IN_W > OUT_W ? IN_W : OUT_W) + 2;

  logic signed [RW-1:0] extIn, halfLsb, lowMask, rounded, cleared;
  logic signed [RW-1:0] maxVal, minVal, satVal;
  int unsigned drop;

  always_comb begin
    drop    = dropBits(rndSel);
    extIn   = RW'(dataIn);
    halfLsb = (drop == 0) ? '0 : (RW'(1) <<< (drop - 1));
    lowMask = (RW'(1) <<< drop) - RW'(1);
    rounded = extIn + halfLsb;
    cleared = rounded & ~lowMask;
    maxVal  = (RW'(1) <<< (OUT_W - 1)) - (RW'(1) <<< drop);
    minVal  = -(RW'(1) <<< (OUT_W - 1));
    if (cleared > maxVal)      satVal = maxVal;
    else if (cleared < minVal) satVal = minVal;
    else                       satVal = cleared;
    wordOut = satVal[OUT_W-1:0];
    if (fmtOffset) wordOut[OUT_W-1] = ~wordOut[OUT_W-1];
  end

endmodule

// File: rtl/leg_route_dp.sv
module leg_route_dp
  import leg_route_pkg::*;
#(
  parameter int LEG_W = 18,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [LEG_W-1:0] upperLeg,
  input  logic signed [LEG_W-1:0] lowerLeg,
  input  logic [2:0]              rndSel,
  input  logic                    fmtOffset,
  input  routeStrobe_t            strobe,
  output logic [OUT_W-1:0]        aOut,
  output logic                    aValid,
  output logic [OUT_W-1:0]        bOut,
  output logic                    bValid
);

  localparam int SUM_W = LEG_W + 1;
  localparam int LANES = 2;

  logic signed [LEG_W-1:0] heldLower;
  logic signed [SUM_W-1:0] laneIn   [LANES];
  logic [OUT_W-1:0]        laneWord [LANES];

  always_comb begin
    unique case (strobe.aSrc)
      SRC_SUM:   laneIn[0] = SUM_W'(upperLeg) + SUM_W'(lowerLeg);
      SRC_UPPER: laneIn[0] = SUM_W'(upperLeg);
      SRC_LOWER: laneIn[0] = SUM_W'(lowerLeg);
      default:   laneIn[0] = SUM_W'(heldLower);
    endcase
    laneIn[1] = SUM_W'(lowerLeg);
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    leg_word_fmt #(.IN_W(SUM_W), .OUT_W(OUT_W)) fmt_i (
      .dataIn   (laneIn[lane]),
      .rndSel   (rndSel),
      .fmtOffset(fmtOffset),
      .wordOut  (laneWord[lane])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldLower <= '0;
      aOut      <= '0;
      bOut      <= '0;
      aValid    <= 1'b0;
      bValid    <= 1'b0;
    end else begin
      aValid <= strobe.loadA;
      bValid <= strobe.loadB;
      if (strobe.holdLower) heldLower <= lowerLeg;
      if (strobe.loadA)     aOut      <= laneWord[0];
      if (strobe.loadB)     bOut      <= laneWord[1];
    end
  end

  // R6: bits below the kept precision are zero in every new word
  a_r6_low_bits_clear: assert property (@(posedge clk) disable iff (!rstN)
    aValid |-> ((aOut & OUT_W'((1 << dropBits($past(rndSel))) - 1)) == '0));

  // R9: port A holds its data when no word is produced
  a_r9_hold_a: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadA |=> $stable(aOut));

  // R3: plain full-precision pass-through of an in-range upper sample is exact
  a_r3_pass_exact: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadA && strobe.aSrc == SRC_UPPER && rndSel == 3'd0 && !fmtOffset &&
     upperLeg >= -(1 <<< (OUT_W - 1)) && upperLeg < (1 <<< (OUT_W - 1)))
      |=> (aOut == $past(upperLeg[OUT_W-1:0])));

endmodule

// File: rtl/leg_route_fmt.sv
module leg_route_fmt
  import leg_route_pkg::*;
#(
  parameter int LEG_W = 18,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    legValid,
  input  logic signed [LEG_W-1:0] upperLeg,
  input  logic signed [LEG_W-1:0] lowerLeg,
  input  logic [1:0]              modeSel,
  input  logic                    intMux,
  input  logic                    fmtOffset,
  input  logic [2:0]              rndSel,
  output logic [OUT_W-1:0]        aOut,
  output logic                    aValid,
  output logic [OUT_W-1:0]        bOut,
  output logic                    bValid
);

  routeStrobe_t strobe;

  leg_route_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .legValid(legValid),
    .modeSel (modeSel),
    .intMux  (intMux),
    .strobe  (strobe)
  );

  leg_route_dp #(.LEG_W(LEG_W), .OUT_W(OUT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .upperLeg (upperLeg),
    .lowerLeg (lowerLeg),
    .rndSel   (rndSel),
    .fmtOffset(fmtOffset),
    .strobe   (strobe),
    .aOut     (aOut),
    .aValid   (aValid),
    .bOut     (bOut),
    .bValid   (bValid)
  );

  // R2: the summing mode never produces a port B word
  a_r2_b_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (legValid && modeSel == 2'b00) |=> !bValid);

endmodule

// File: tb/leg_route_fmt_tb_top.sv
module leg_route_fmt_tb_top;

  localparam int LEG_W = 18;
  localparam int OUT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic legValid = 1'b0;
  logic signed [LEG_W-1:0] upperLeg = '0, lowerLeg = '0;
  logic [1:0] modeSel = '0;
  logic intMux = 1'b0, fmtOffset = 1'b0;
  logic [2:0] rndSel = '0;
  logic [OUT_W-1:0] aOut, bOut;
  logic aValid, bValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  leg_route_fmt #(.LEG_W(LEG_W), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rstN(rstN), .legValid(legValid), .upperLeg(upperLeg),
    .lowerLeg(lowerLeg), .modeSel(modeSel), .intMux(intMux),
    .fmtOffset(fmtOffset), .rndSel(rndSel), .aOut(aOut), .aValid(aValid),
    .bOut(bOut), .bValid(bValid));

  function automatic int expDrop(input int sel);
    int tbl [8] = '{0, 1, 2, 3, 4, 6, 7, 8};
    return tbl[sel];
  endfunction

  // R6 R7 R8 reference: round half up, clear, clamp, encode
  function automatic logic [15:0] refWord(input int v, input int sel, input bit ofs);
    int d, r, hi;
    logic [15:0] w;
    d  = expDrop(sel);
    r  = (d > 0) ? v + (1 << (d - 1)) : v;
    r  = (r >>> d) << d;
    hi = 32768 - (1 << d);
    if (r > hi) r = hi;
    if (r < -32768) r = -32768;
    w = r[15:0];
    if (ofs) w = w ^ 16'h8000;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (mode=%b int=%b rnd=%0d fmt=%b)",
               req, act, exp, modeSel, intMux, rndSel, fmtOffset);
    end
  endtask

  task automatic runPair(input int up, input int lo);
    logic [15:0] lastB;
    int m;
    m = modeSel;
    lastB = bOut;
    @(negedge clk);
    legValid = 1'b1;
    upperLeg = up[LEG_W-1:0];
    lowerLeg = lo[LEG_W-1:0];
    @(negedge clk);
    legValid = 1'b0;
    if (m == 0) begin
      chk("R2 aValid", aValid, 1);
      chk("R2 aOut", aOut, refWord(up + lo, rndSel, fmtOffset));
      chk("R2 bValid", bValid, 0);
      chk("R9 bOut hold", bOut, lastB);
    end else if (m == 2 || !intMux) begin
      chk(m == 2 ? "R3 valids" : "R5 valids", {aValid, bValid}, 2'b11);
      chk(m == 2 ? "R3 aOut" : "R5 aOut", aOut, refWord(up, rndSel, fmtOffset));
      chk(m == 2 ? "R3 bOut" : "R5 bOut", bOut, refWord(lo, rndSel, fmtOffset));
    end else begin
      chk("R4 first valid", {aValid, bValid}, 2'b10);
      chk("R4 first aOut", aOut, refWord(up, rndSel, fmtOffset));
      @(negedge clk);
      chk("R4 second valid", {aValid, bValid}, 2'b10);
      chk("R4 second aOut", aOut, refWord(lo, rndSel, fmtOffset));
    end
  endtask

  initial begin
    int ups [8] = '{100, 32767, -32768, 131071, -131072, 4660, 383, -129};
    int los [8] = '{-37, 1, -1, 131071, -131072, -22136, 0, 127};
    logic [15:0] keepA;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 during reset", {aValid, bValid, aOut, bOut}, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {aValid, bValid, aOut, bOut}, '0);

    for (int m = 0; m < 4; m++)
      for (int im = 0; im < 2; im++)
        for (int f = 0; f < 2; f++)
          for (int r = 0; r < 8; r++) begin
            modeSel = m[1:0]; intMux = im[0]; fmtOffset = f[0]; rndSel = r[2:0];
            for (int k = 0; k < 8; k++) runPair(ups[k], los[k]);
            // rounding edge: exactly half an LSB below a kept step, and one below it
            runPair((1 << expDrop(r)) * 5 - (expDrop(r) > 0 ? (1 << (expDrop(r) - 1)) : 0), 3);
            runPair(-(1 << expDrop(r)) * 7 - 1, -2);
            keepA = aOut;
            @(negedge clk);
            chk("R9 idle valids", {aValid, bValid}, 2'b00);
            chk("R9 aOut hold", aOut, keepA);
          end

    // R10: a new pair in the second interleave slot is dropped
    modeSel = 2'b01; intMux = 1'b1; fmtOffset = 1'b0; rndSel = 3'd0;
    @(negedge clk);
    legValid = 1'b1; upperLeg = 18'sd1000; lowerLeg = 18'sd2000;
    @(negedge clk);
    upperLeg = 18'sd3000; lowerLeg = 18'sd4000;
    chk("R10 first aOut", aOut, 16'd1000);
    @(negedge clk);
    legValid = 1'b0;
    chk("R10 held lower", {aValid, aOut}, {1'b1, 16'd2000});
    @(negedge clk);
    chk("R10 dropped pair", {aValid, bValid, aOut}, {2'b00, 16'd2000});
    @(negedge clk);
    chk("R10 still idle", {aValid, bValid}, 2'b00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule